// File: doc/BRIEF.md
# Serial Flash Auto-Increment Word Programmer

This block writes a stream of bytes into a serial NOR flash whose fast write path is an auto-address-increment word command, not a page program. It takes a start address and a byte count, pulls the data bytes from a valid/ready stream, and issues every command as a sequence of bytes to an SPI byte engine that sits outside the block. The engine shifts one byte per handshake and raises chip select for the whole frame that ends at a byte flagged as last.

Most of the data goes out as two-byte words under the auto-increment command. A single leading byte at an odd address and a single trailing byte are each written with the ordinary byte-program command. The device's busy flag is polled after every program frame. The word run is closed with a write-disable command. If a status poll stays busy for too long, the sequence is abandoned, write-disable is sent and the error flag is raised. A counter reports how many data bytes the engine has accepted.

Top module: `flash_word_prog`

## Requirements
- R1: After reset, req_ready is 1 and eng_valid, in_ready, done and err are 0, and sent_count is 0.
- R2: A request with req_len of zero produces no engine traffic and pulses done with err 0.
- R3: A nonzero request starts with status polls. Each poll is the frame 0x05 followed by a last byte 0x00, and bit 0 of the reply to the second byte means busy. Polls repeat until an idle reply arrives. Then the single-byte frame 0x06 (write enable) is sent.
- R4: For an odd start address, the next frame is byte program: 0x02, then the three address bytes most significant first, then one data byte flagged last. After this frame the address advances by one and the remaining count drops by one.
- R5: While two or more bytes remain, each word frame starts with 0xAD and ends with two data bytes, the second flagged last. Only the first word frame of a run carries the three address bytes, and these hold the current even address.
- R6: After every program frame (0x02 or 0xAD), no frame other than a status poll is sent until a poll has returned idle.
- R7: After the word loop, the single-byte frame 0x04 (write disable) is sent and is followed by polling to idle. This happens even when no word was written.
- R8: If exactly one byte then remains, the block sends 0x06, a byte-program frame with the current address, a poll to idle, and then 0x04, after which it finishes.
- R9: A run of POLL_MAX consecutive busy replies ends the sequence. The block sends the frame 0x04, pulses done with err 1, and writes no further data.
- R10: sent_count is cleared when a request is accepted and rises by one for each data byte the engine accepts. On success it equals req_len at done.
- R11: in_ready is high only in the cycle a data byte is handed to the engine. Stream bytes are used once each and in order.
- R12: While a non-data byte waits for eng_ready, eng_valid, eng_tx and eng_last stay stable.
- R13: done is a one-cycle pulse, and req_ready is low from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | AW | Start byte address in the flash |
| req_len | input | LW | Number of data bytes to write |
| in_valid | input | 1 | Data stream byte available |
| in_ready | output | 1 | Data stream byte taken this cycle |
| in_data | input | 8 | Data stream byte |
| eng_valid | output | 1 | Byte offered to the SPI engine |
| eng_ready | input | 1 | Engine has shifted the byte; reply is valid |
| eng_tx | output | 8 | Byte to shift out |
| eng_last | output | 1 | Byte ends the frame (chip select released after it) |
| eng_rx | input | 8 | Byte shifted in during the accepted transfer |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | Last request aborted by poll timeout |
| sent_count | output | LW | Data bytes accepted by the engine in this request |

## Verification
The bench sweeps both address parities against lengths from zero to nine. This covers the combinations of head byte, word run and tail byte, including a lone odd byte, a single word, and a single even byte that needs the write-disable, re-enable, byte-program path. A design that puts the address into every word frame, skips the write-disable after an empty word loop, or forgets the second write enable before the tail produces a frame log that differs from the one the bench builds from the rules. A model of the device keeps reporting busy for a while after each program frame, and the bench flags any command sent before an idle poll. Two stuck-busy cases, one before any write and one after the first program frame, check that the abort comes after exactly POLL_MAX busy replies and that sent_count stops at the bytes actually sent.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_BYTE = 8'h02;
  localparam logic [7:0] OPC_WORD = 8'hAD;
  localparam logic [7:0] FILLER   = 8'h00;

  // one state per kind of byte put on the engine port
  typedef enum logic [3:0] {
    ST_IDLE, ST_PCMD, ST_PDUM, ST_WREN, ST_OPC, ST_ADR, ST_DAT, ST_WRDI, ST_FIN
  } step_e;

  // where the sequence stands when a status poll completes
  typedef enum logic [2:0] {
    PH_PRE, PH_HEAD, PH_WORD, PH_LOOPEND, PH_TAIL, PH_END, PH_ABORT
  } phase_e;

  // address byte idx of an nb-byte big-endian address
  function automatic logic [7:0] addr_byte(input logic [31:0] a,
                                           input int unsigned idx,
                                           input int unsigned nb);
    return 8'(a >> (8 * (nb - 1 - idx)));
  endfunction

  function automatic logic word_fits(input logic [31:0] remaining);
    return remaining >= 32'd2;
  endfunction

  function automatic logic one_left(input logic [31:0] remaining);
    return remaining == 32'd1;
  endfunction

endpackage

// File: rtl/fwp_poll_timer.sv
module fwp_poll_timer #(
  parameter int POLL_MAX = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample,
  input  logic busy,
  output logic expired
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt;

  assign expired = sample && busy && (cnt == CW'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || expired || (sample && !busy)) begin
      cnt <= '0;
    end else if (sample && busy) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R9: the count of busy replies never reaches the limit without expiring
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(POLL_MAX));

endmodule

// File: rtl/fwp_progress.sv
module fwp_progress #(
  parameter int AW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] rem,
  output logic [LW-1:0] sent
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      rem      <= '0;
      sent     <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      rem      <= load_len;
      sent     <= '0;
    end else if (step) begin
      cur_addr <= cur_addr + AW'(1);
      rem      <= rem - LW'(1);
      sent     <= sent + LW'(1);
    end
  end

  // R10: a data byte is only sent while bytes remain
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem != '0));

  // R10: sent plus remaining stays equal to the requested length
  p_sum_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (LW'(sent + rem) == $past(LW'(sent + rem))));

endmodule

// File: rtl/fwp_tx_mux.sv
module fwp_tx_mux
  import fwp_pkg::*;
#(
  parameter int NB = 3,
  parameter int IW = 2
) (
  input  step_e         st,
  input  logic [7:0]    op,
  input  logic [31:0]   addr,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    dat_left,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          valid,
  output logic [7:0]    tx,
  output logic          last
);

  always_comb begin
    valid = 1'b1;
    tx    = FILLER;
    last  = 1'b0;
    unique case (st)
      ST_PCMD: tx = OPC_RDSR;
      ST_PDUM: begin tx = FILLER; last = 1'b1; end
      ST_WREN: begin tx = OPC_WREN; last = 1'b1; end
      ST_OPC:  tx = op;
      ST_ADR:  tx = addr_byte(addr, 32'(idx), NB);
      ST_DAT:  begin
        valid = in_valid;
        tx    = in_data;
        last  = (dat_left == 2'd1);
      end
      ST_WRDI: begin tx = OPC_WRDI; last = 1'b1; end
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
  import fwp_pkg::*;
#(
  parameter int AW       = 24,
  parameter int LW       = 16,
  parameter int POLL_MAX = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          eng_valid,
  input  logic          eng_ready,
  output logic [7:0]    eng_tx,
  output logic          eng_last,
  input  logic [7:0]    eng_rx,
  output logic          done,
  output logic          err,
  output logic [LW-1:0] sent_count
);
  localparam int NB = (AW + 7) / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  step_e         st;
  phase_e        ph;
  logic [7:0]    op;
  logic [IW-1:0] idx;
  logic [1:0]    dat_left;
  logic          first_word;
  logic          err_q;

  logic [AW-1:0] cur_addr;
  logic [LW-1:0] rem;

  // named internal events
  logic hs, poll_reply, dev_busy, data_step, load, timeout;
  logic more_words, tail_one, addr_odd;

  assign hs         = eng_valid && eng_ready;
  assign poll_reply = (st == ST_PDUM) && hs;
  assign dev_busy   = eng_rx[0];
  assign data_step  = (st == ST_DAT) && hs;
  assign load       = (st == ST_IDLE) && req_valid;
  assign more_words = word_fits(32'(rem));
  assign tail_one   = one_left(32'(rem));
  assign addr_odd   = cur_addr[0];

  assign req_ready  = (st == ST_IDLE);
  assign in_ready   = data_step;
  assign done       = (st == ST_FIN);
  assign err        = err_q;

  fwp_progress #(.AW(AW), .LW(LW)) u_prog (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(req_addr),
    .load_len(req_len), .step(data_step), .cur_addr(cur_addr),
    .rem(rem), .sent(sent_count)
  );

  fwp_poll_timer #(.POLL_MAX(POLL_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(load), .sample(poll_reply),
    .busy(dev_busy), .expired(timeout)
  );

  fwp_tx_mux #(.NB(NB), .IW(IW)) u_mux (
    .st(st), .op(op), .addr(32'(cur_addr)), .idx(idx), .dat_left(dat_left),
    .in_valid(in_valid), .in_data(in_data), .valid(eng_valid),
    .tx(eng_tx), .last(eng_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ph         <= PH_PRE;
      op         <= FILLER;
      idx        <= '0;
      dat_left   <= '0;
      first_word <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          err_q      <= 1'b0;
          first_word <= 1'b1;
          ph         <= PH_PRE;
          st         <= (req_len == '0) ? ST_FIN : ST_PCMD;
        end
        ST_PCMD: if (hs) st <= ST_PDUM;
        ST_PDUM: if (hs) begin
          if (timeout) begin
            err_q <= 1'b1;
            ph    <= PH_ABORT;
            st    <= ST_WRDI;
          end else if (dev_busy) begin
            st <= ST_PCMD;
          end else begin
            unique case (ph)
              PH_PRE: st <= ST_WREN;
              PH_HEAD, PH_WORD: begin
                if (more_words) begin
                  op       <= OPC_WORD;
                  dat_left <= 2'd2;
                  ph       <= PH_WORD;
                  st       <= ST_OPC;
                end else begin
                  ph <= PH_LOOPEND;
                  st <= ST_WRDI;
                end
              end
              PH_LOOPEND: begin
                if (tail_one) begin
                  ph <= PH_TAIL;
                  st <= ST_WREN;
                end else begin
                  st <= ST_FIN;
                end
              end
              PH_TAIL: begin
                ph <= PH_END;
                st <= ST_WRDI;
              end
              default: st <= ST_FIN;
            endcase
          end
        end
        ST_WREN: if (hs) begin
          if (ph == PH_TAIL || addr_odd) begin
            op       <= OPC_BYTE;
            dat_left <= 2'd1;
            if (ph != PH_TAIL) ph <= PH_HEAD;
            st       <= ST_OPC;
          end else if (more_words) begin
            op       <= OPC_WORD;
            dat_left <= 2'd2;
            ph       <= PH_WORD;
            st       <= ST_OPC;
          end else begin
            ph <= PH_LOOPEND;
            st <= ST_WRDI;
          end
        end
        ST_OPC: if (hs) begin
          idx <= '0;
          if (op == OPC_WORD && !first_word) begin
            st <= ST_DAT;
          end else begin
            if (op == OPC_WORD) first_word <= 1'b0;
            st <= ST_ADR;
          end
        end
        ST_ADR: if (hs) begin
          if (idx == IW'(NB - 1)) st <= ST_DAT;
          else                     idx <= idx + IW'(1);
        end
        ST_DAT: if (hs) begin
          dat_left <= dat_left - 2'd1;
          if (dat_left == 2'd1) st <= ST_PCMD;
        end
        ST_WRDI: if (hs) begin
          st <= (ph == PH_LOOPEND) ? ST_PCMD : ST_FIN;
        end
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12: command bytes stay put until the engine takes them
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready && st != ST_DAT) |=>
      (eng_valid && $stable(eng_tx) && $stable(eng_last)));

  // R13: done lasts one cycle and the block is then free again
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R5: a word command is only started with two bytes left
  p_word_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OPC && op == OPC_WORD) |-> (rem >= LW'(2)));

  // R9: an expired poll is followed by write-disable with err set
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_reply && timeout) |=> (eng_valid && eng_tx == OPC_WRDI && err));

  // R11: the stream moves only with an engine handshake
  p_in_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (eng_valid && eng_ready && in_valid));

endmodule

// File: tb/sim_flash_word_prog.sv
`timescale 1ns/1ps
module sim_flash_word_prog;
  localparam int AW = 24;
  localparam int LW = 8;
  localparam int PMAX = 6;
  localparam int BUSY_N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic in_valid, in_ready;
  logic [7:0] in_data;
  logic eng_valid;
  logic eng_ready = 1'b0;
  logic [7:0] eng_tx;
  logic eng_last;
  logic [7:0] eng_rx = 8'h00;
  logic done, err;
  logic [LW-1:0] sent_count;

  always #2 clk = ~clk;

  flash_word_prog #(.AW(AW), .LW(LW), .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .eng_valid(eng_valid),
    .eng_ready(eng_ready), .eng_tx(eng_tx), .eng_last(eng_last),
    .eng_rx(eng_rx), .done(done), .err(err), .sent_count(sent_count)
  );

  int checks = 0;
  int failures = 0;

  // written by the main process only
  logic [7:0] src [0:15];
  int src_len = 0;
  int run_id = 0;
  int pre_busy = 0;
  bit stuck_start = 0;
  bit stuck_arm = 0;
  logic [7:0] exp_b [0:255];
  bit exp_l [0:255];
  int exp_n = 0;

  // written by the engine model only
  int seen_run = 0;
  int used = 0;
  bit take = 0;
  int busy_left = 0;
  bit stuck = 0;
  bit idle_ok = 0;
  int order_bad = 0;
  int stuck_polls = 0;
  int pos = 0;
  logic [7:0] fop = 8'h00;
  logic [7:0] act_b [0:255];
  bit act_l [0:255];
  int act_n = 0;

  assign in_valid = (used < src_len);
  assign in_data  = src[used[3:0]];

  // SPI engine plus device model
  initial begin
    forever begin
      @(negedge clk);
      if (seen_run != run_id) begin
        seen_run = run_id; used = 0; take = 0; busy_left = pre_busy;
        stuck = stuck_start; idle_ok = 0; order_bad = 0; stuck_polls = 0;
        pos = 0; act_n = 0;
      end
      if (eng_ready) begin
        eng_ready = 1'b0;
        if (take) begin used = used + 1; take = 0; end
      end else if (eng_valid && rst_n) begin
        if (pos == 0) fop = eng_tx;
        eng_rx = 8'h00;
        if (fop == 8'h05 && pos == 1) begin
          if (stuck) begin eng_rx = 8'h01; stuck_polls++; end
          else if (busy_left > 0) begin eng_rx = 8'h01; busy_left--; end
          else idle_ok = 1;
        end
        if (fop != 8'h05) begin
          if (pos == 0 && !idle_ok && !stuck) order_bad++;   // R6
          if (act_n < 256) begin act_b[act_n] = eng_tx; act_l[act_n] = eng_last; end
          act_n++;
        end
        if (eng_last) begin
          if (fop == 8'h02 || fop == 8'hAD) begin
            idle_ok = 0; busy_left = BUSY_N;
            if (stuck_arm) stuck = 1;
          end
          pos = 0;
        end else pos++;
        eng_ready = 1'b1;
        #1;
        if (in_ready) take = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit l);
    exp_b[exp_n] = b; exp_l[exp_n] = l; exp_n++;
  endtask

  task automatic push_addr(input int a);
    push(8'(a >> 16), 0); push(8'(a >> 8), 0); push(8'(a), 0);
  endtask

  // expected non-poll frames; mode 0 normal, 1 stuck after first program, 2 stuck at once
  task automatic build(input int addr, input int len, input int mode, output int exp_sent);
    int a, r, k;
    bit first;
    exp_n = 0; exp_sent = 0;
    if (len == 0) return;
    if (mode == 2) begin push(8'h04, 1); return; end
    push(8'h06, 1);                                          // R3
    a = addr; r = len; k = 0;
    if (a % 2 == 1) begin                                    // R4
      push(8'h02, 0); push_addr(a); push(src[k], 1);
      k++; a++; r--; exp_sent = 1;
      if (mode == 1) begin push(8'h04, 1); return; end
    end
    first = 1;
    while (r >= 2) begin                                     // R5
      push(8'hAD, 0);
      if (first) push_addr(a);
      push(src[k], 0); push(src[k+1], 1);
      k += 2; a += 2; r -= 2; exp_sent += 2;
      if (mode == 1 && first) begin push(8'h04, 1); return; end
      first = 0;
    end
    push(8'h04, 1);                                          // R7
    if (r == 1) begin                                        // R8
      push(8'h06, 1); push(8'h02, 0); push_addr(a); push(src[k], 1);
      push(8'h04, 1); exp_sent++;
    end
  endtask

  task automatic run(input int addr, input int len, input int mode, input int pb);
    int exp_sent, waited, mism;
    for (int i = 0; i < 16; i++) src[i] = 8'(addr * 7 + i * 29 + 3);
    src_len = len; pre_busy = pb;
    stuck_start = (mode == 2); stuck_arm = (mode == 1);
    build(addr, len, mode, exp_sent);
    run_id++;
    @(negedge clk); @(negedge clk);
    req_addr = AW'(addr); req_len = LW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len != 0) chk(req_ready == 1'b0, "R13 req_ready while busy", int'(req_ready), 0);
    waited = 0;
    while (!done && waited < 3000) begin @(negedge clk); waited++; end
    chk(done == 1'b1, "R13 done reached", int'(done), 1);
    chk(err == (mode != 0), "R9 err flag", int'(err), int'(mode != 0));
    chk(int'(sent_count) == exp_sent, "R10 sent_count", int'(sent_count), exp_sent);
    chk(used == exp_sent, "R11 stream bytes used", used, exp_sent);
    @(negedge clk);
    chk(done == 1'b0, "R13 done single pulse", int'(done), 0);
    if (len == 0) chk(act_n == 0, "R2 no traffic", act_n, 0);
    chk(act_n == exp_n, "R4/R5/R7/R8 frame byte count", act_n, exp_n);
    mism = -1;
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (mism < 0 && (act_b[i] != exp_b[i] || act_l[i] != exp_l[i])) mism = i;
    if (mism >= 0)
      chk(0, "R3/R4/R5/R7/R8 frame byte", int'({act_l[mism], act_b[mism]}),
          int'({exp_l[mism], exp_b[mism]}));
    else chk(1, "R5 frames", 0, 0);
    chk(order_bad == 0, "R6 command before idle poll", order_bad, 0);
    if (mode != 0) chk(stuck_polls == PMAX, "R9 busy polls before abort", stuck_polls, PMAX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(eng_valid == 1'b0, "R1 eng_valid", int'(eng_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R1 done/err", int'({done, err}), 0);
    chk(sent_count == '0 && in_ready == 1'b0, "R1 sent_count", int'(sent_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 2; b++)
      for (int off = 0; off < 4; off++)
        for (int len = 0; len < 10; len++)
          run((b == 0 ? 0 : 24'h5A3C7C) + off, len, 0, (len % 3 == 0) ? 3 : 0);
    run(24'h000100, 6, 1, 0);   // R9 stuck after an even first word
    run(24'h000101, 6, 1, 0);   // R9 stuck after an odd head byte
    run(24'h000200, 4, 2, 0);   // R9 stuck before anything is written
    run(24'h000203, 5, 0, 4);   // recovery after aborts
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule